// File: doc/BRIEF.md
# Local Interrupt Controller Register Front End

This block is the register access side of a local interrupt controller. It serves a small word-indexed register file. Each access gives a byte address, a byte count and up to 64 bits of write data. The index is byte address bits 11:4. A strap input picks one of two modes. Legacy mode behaves as a memory-mapped window with 32-bit registers. Extended mode treats every access as a full 64-bit register access. The same index can have a different layout, width or legality in each mode.

Writes to the command register (index 0x30) are decoded into one inter-processor interrupt request, and so are writes to the self-interrupt register (index 0x3F). The request is held on a valid/ready output until the consumer takes it. An access that is illegal in the current mode raises a one-cycle fault and changes nothing. A write to an index the block does not define sets a sticky bit in the error status register.

Top module: `ic_regfront`

## Requirements
- R1: A command write (index 0x30) issues a request with vector = data[7:0], delivery = data[10:8], logical destination = data[11], level trigger = data[15], shorthand = data[19:18]. In legacy mode the destination is bits 31:24 of the stored command-high register (index 0x31), zero-extended to 32 bits.
- R2: In extended mode a command write stores data[63:32] as command-high and uses all 32 of those bits as the destination. A 64-bit read of index 0x30 returns {command-high, command-low}.
- R3: In extended mode, writes to index 0x02, 0x0D, 0x0E or 0x31 fault, and so does a read of 0x0E. A faulting access leaves every register unchanged, raises no request and reads as zero.
- R4: Reading index 0x02 returns the 8-bit local ID in bits 31:24 in legacy mode and the full 32-bit strap ID in extended mode. A legacy write loads the local ID from data[31:24]. The local ID resets to strap ID bits 7:0.
- R5: Reading index 0x0D returns the stored 8-bit logical ID in bits 31:24 in legacy mode. In extended mode it returns {strap ID bits 19:4, a 16-bit one-hot of strap ID bits 3:0}.
- R6: Reading index 0x0E returns the 4-bit format nibble in bits 31:28 with ones in bits 27:0. A legacy write loads the nibble from data[31:28]. The nibble resets to 0xF.
- R7: A write to index 0x3F issues a request with vector = data[7:0], shorthand 1, fixed delivery (0), edge trigger, physical destination mode and destination 0.
- R8: A write to an undefined index sets bit 7 of the error status register (read at index 0x28). The bit stays set until reset, and the write raises no fault.
- R9: In legacy mode an access narrower than 4 bytes reads as zero, and as a write it has no effect. Extended mode ignores the byte count.
- R10: Fault, read data and a new request all appear in the cycle after the access. Fault is high for exactly one cycle per faulting access.
- R11: A request stays valid with unchanged fields until a cycle in which ready is high.
- R12: A request-issuing write that arrives while a request is pending without ready faults and is dropped. If ready is high in the same cycle, the old request is taken and the new one is loaded.
- R13: After reset there is no request, no fault and no read valid, and the error status register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 selects extended mode |
| strap_id | input | 32 | Initial ID of this controller |
| acc_valid | input | 1 | Register access this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address; index is bits 11:4 |
| acc_size | input | 4 | Access width in bytes |
| acc_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| fault | output | 1 | Illegal access pulse |
| ipi_valid | output | 1 | Request pending |
| ipi_ready | input | 1 | Consumer takes the request |
| ipi_dest | output | 32 | Destination |
| ipi_logical | output | 1 | Logical destination mode |
| ipi_delivery | output | 3 | Delivery mode |
| ipi_vector | output | 8 | Vector |
| ipi_level | output | 1 | Level trigger |
| ipi_shorthand | output | 2 | Destination shorthand |

## Verification
Two events can fall in the same cycle: the consumer taking a pending request, and a new command or self-interrupt write. The bench holds a request with ready low and sends a second command write, which must fault and leave the old fields in place. It then repeats the write with ready high in that same cycle, and the new fields must load with no fault. A behavioural model of the request slot, updated on every edge, judges both cases.

// File: rtl/ic_pkg.sv
package ic_pkg;

   localparam logic [7:0] IX_ID     = 8'h02;
   localparam logic [7:0] IX_LOGID  = 8'h0D;
   localparam logic [7:0] IX_FMT    = 8'h0E;
   localparam logic [7:0] IX_ERR    = 8'h28;
   localparam logic [7:0] IX_CMD    = 8'h30;
   localparam logic [7:0] IX_CMD_HI = 8'h31;
   localparam logic [7:0] IX_SELF   = 8'h3F;

   typedef enum logic [2:0] {
      K_UNDEF,
      K_ID,
      K_LOGID,
      K_FMT,
      K_ERR,
      K_CMD,
      K_CMD_HI,
      K_SELF
   } reg_kind_e;

   typedef struct packed {
      logic [31:0] dest;
      logic        logical;
      logic [2:0]  delivery;
      logic [7:0]  vector;
      logic        level;
      logic [1:0]  shorthand;
   } ipi_req_t;

endpackage

// File: rtl/ic_decode.sv
module ic_decode
   import ic_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              acc_valid,
   input  logic              acc_we,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [3:0]        acc_size,
   input  logic              ext_mode,
   input  logic              ipi_busy,
   output reg_kind_e         kind,
   output logic              narrow,
   output logic              rd_en,
   output logic              wr_en,
   output logic              issue,
   output logic              undef_wr,
   output logic              mode_fault,
   output logic              busy_fault
);

   logic [7:0] idx;
   logic       hi_zero;
   logic       live;
   logic       restricted;
   logic       is_ipi;
   logic       unused_low;

   assign idx        = acc_addr[11:4];
   assign unused_low = ^acc_addr[3:0];

   generate
      if (ADDR_W > 12) begin : g_hi
         assign hi_zero = (acc_addr[ADDR_W-1:12] == '0);
      end else begin : g_nohi
         assign hi_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      kind = K_UNDEF;
      if (hi_zero) begin
         case (idx)
            IX_ID:     kind = K_ID;
            IX_LOGID:  kind = K_LOGID;
            IX_FMT:    kind = K_FMT;
            IX_ERR:    kind = K_ERR;
            IX_CMD:    kind = K_CMD;
            IX_CMD_HI: kind = K_CMD_HI;
            IX_SELF:   kind = K_SELF;
            default:   kind = K_UNDEF;
         endcase
      end
   end

   assign narrow = !ext_mode && (acc_size < 4'd4);
   assign live   = acc_valid && !narrow;

   always_comb begin
      restricted = 1'b0;
      if (ext_mode) begin
         if (acc_we)
            restricted = (kind == K_ID) || (kind == K_LOGID) ||
                         (kind == K_FMT) || (kind == K_CMD_HI);
         else
            restricted = (kind == K_FMT);
      end
   end

   assign is_ipi     = acc_we && ((kind == K_CMD) || (kind == K_SELF));
   assign mode_fault = live && restricted;
   assign busy_fault = live && is_ipi && ipi_busy;
   assign issue      = live && is_ipi && !ipi_busy;
   assign wr_en      = live && acc_we && !restricted && !busy_fault && (kind != K_UNDEF);
   assign undef_wr   = live && acc_we && (kind == K_UNDEF);
   assign rd_en      = acc_valid && !acc_we;

endmodule

// File: rtl/ic_regs.sv
module ic_regs
   import ic_pkg::*;
#(
   parameter int MEMBER_LOG = 4,
   parameter int ERR_BIT    = 7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ext_mode,
   input  logic [31:0] strap_id,
   input  reg_kind_e   kind,
   input  logic        wr_en,
   input  logic        undef_wr,
   input  logic        rd_en,
   input  logic        rd_zero,
   input  logic [63:0] wdata,
   output logic [31:0] cmd_hi,
   output logic        rd_valid,
   output logic [63:0] rd_data
);

   localparam int MEMBER_W = 1 << MEMBER_LOG;
   localparam int CL_W     = 32 - MEMBER_W;

   generate
      if (MEMBER_LOG < 1 || MEMBER_LOG > 4) begin : g_bad_member
         $fatal(1, "MEMBER_LOG must be in 1..4");
      end
      if (ERR_BIT < 0 || ERR_BIT > 31) begin : g_bad_err
         $fatal(1, "ERR_BIT must be in 0..31");
      end
   endgenerate

   logic [7:0]  id_q;
   logic [7:0]  logid_q;
   logic [3:0]  fmt_q;
   logic [31:0] cmd_lo_q;
   logic [31:0] cmd_hi_q;
   logic [31:0] err_q;
   logic [31:0] ext_logid;
   logic [MEMBER_W-1:0] member;
   logic [63:0] rd_val;

   assign member    = MEMBER_W'(1) << strap_id[MEMBER_LOG-1:0];
   assign ext_logid = {strap_id[CL_W+MEMBER_LOG-1:MEMBER_LOG], member};
   assign cmd_hi    = cmd_hi_q;

   always_comb begin
      case (kind)
         K_ID:     rd_val = ext_mode ? {32'b0, strap_id} : {32'b0, id_q, 24'b0};
         K_LOGID:  rd_val = ext_mode ? {32'b0, ext_logid} : {32'b0, logid_q, 24'b0};
         K_FMT:    rd_val = {32'b0, fmt_q, 28'hFFF_FFFF};
         K_ERR:    rd_val = {32'b0, err_q};
         K_CMD:    rd_val = ext_mode ? {cmd_hi_q, cmd_lo_q} : {32'b0, cmd_lo_q};
         K_CMD_HI: rd_val = {32'b0, cmd_hi_q};
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q     <= strap_id[7:0];
         logid_q  <= '0;
         fmt_q    <= 4'hF;
         cmd_lo_q <= '0;
         cmd_hi_q <= '0;
         err_q    <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         if (wr_en) begin
            case (kind)
               K_ID:    id_q    <= wdata[31:24];
               K_LOGID: logid_q <= wdata[31:24];
               K_FMT:   fmt_q   <= wdata[31:28];
               K_CMD: begin
                  cmd_lo_q <= wdata[31:0];
                  if (ext_mode) cmd_hi_q <= wdata[63:32];
               end
               K_CMD_HI: cmd_hi_q <= wdata[31:0];
               default: ;
            endcase
         end
         if (undef_wr) err_q[ERR_BIT] <= 1'b1;
         rd_valid <= rd_en;
         rd_data  <= (rd_en && !rd_zero) ? rd_val : '0;
      end
   end

   // R8: the illegal-index bit is sticky until reset
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_q[ERR_BIT] |=> err_q[ERR_BIT]);

   // R3: a restricted extended-mode write never reaches the ID or format storage
   p_ext_no_id_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_mode && !wr_en) |=> $stable(id_q) && $stable(fmt_q) && $stable(logid_q));

endmodule

// File: rtl/ic_ipi_port.sv
module ic_ipi_port
   import ic_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        issue,
   input  reg_kind_e   kind,
   input  logic        ext_mode,
   input  logic [63:0] wdata,
   input  logic [31:0] cmd_hi,
   input  logic        ready,
   output logic        valid,
   output logic        busy,
   output ipi_req_t    req
);

   ipi_req_t nreq;
   logic     unused_bits;

   assign unused_bits = ^{wdata[14:12], wdata[17:16], wdata[31:20], cmd_hi[23:0]};

   always_comb begin
      nreq = '0;
      if (kind == K_SELF) begin
         nreq.vector    = wdata[7:0];
         nreq.shorthand = 2'd1;
      end else begin
         nreq.vector    = wdata[7:0];
         nreq.delivery  = wdata[10:8];
         nreq.logical   = wdata[11];
         nreq.level     = wdata[15];
         nreq.shorthand = wdata[19:18];
         nreq.dest      = ext_mode ? wdata[63:32] : {24'b0, cmd_hi[31:24]};
      end
   end

   assign busy = valid && !ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         req   <= '0;
      end else if (issue) begin
         valid <= 1'b1;
         req   <= nreq;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end

   // R11: a pending request holds its fields until taken
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(req)));

   // R1: a legacy command request carries only an 8-bit destination
   p_legacy_dest_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !ext_mode && kind == K_CMD) |=> (req.dest[31:8] == 24'b0));

   // R7: self requests are fixed, edge, shorthand 1
   p_self_fmt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && kind == K_SELF) |=> (req.shorthand == 2'd1 && req.delivery == 3'd0 && !req.level));

endmodule

// File: rtl/ic_regfront.sv
module ic_regfront
   import ic_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int MEMBER_LOG = 4,
   parameter int ERR_BIT    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_mode,
   input  logic [31:0]       strap_id,
   input  logic              acc_valid,
   input  logic              acc_we,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [3:0]        acc_size,
   input  logic [63:0]       acc_wdata,
   output logic              rd_valid,
   output logic [63:0]       rd_data,
   output logic              fault,
   output logic              ipi_valid,
   input  logic              ipi_ready,
   output logic [31:0]       ipi_dest,
   output logic              ipi_logical,
   output logic [2:0]        ipi_delivery,
   output logic [7:0]        ipi_vector,
   output logic              ipi_level,
   output logic [1:0]        ipi_shorthand
);

   generate
      if (ADDR_W < 12) begin : g_bad_addr
         $fatal(1, "ADDR_W must be at least 12");
      end
   endgenerate

   reg_kind_e   kind;
   logic        narrow, rd_en, wr_en, issue, undef_wr, mode_fault, busy_fault;
   logic        busy;
   logic [31:0] cmd_hi;
   ipi_req_t    req;

   ic_decode #(.ADDR_W(ADDR_W)) u_dec (
      .acc_valid  (acc_valid),
      .acc_we     (acc_we),
      .acc_addr   (acc_addr),
      .acc_size   (acc_size),
      .ext_mode   (ext_mode),
      .ipi_busy   (busy),
      .kind       (kind),
      .narrow     (narrow),
      .rd_en      (rd_en),
      .wr_en      (wr_en),
      .issue      (issue),
      .undef_wr   (undef_wr),
      .mode_fault (mode_fault),
      .busy_fault (busy_fault)
   );

   ic_regs #(.MEMBER_LOG(MEMBER_LOG), .ERR_BIT(ERR_BIT)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_mode (ext_mode),
      .strap_id (strap_id),
      .kind     (kind),
      .wr_en    (wr_en),
      .undef_wr (undef_wr),
      .rd_en    (rd_en),
      .rd_zero  (narrow || mode_fault),
      .wdata    (acc_wdata),
      .cmd_hi   (cmd_hi),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   ic_ipi_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue    (issue),
      .kind     (kind),
      .ext_mode (ext_mode),
      .wdata    (acc_wdata),
      .cmd_hi   (cmd_hi),
      .ready    (ipi_ready),
      .valid    (ipi_valid),
      .busy     (busy),
      .req      (req)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) fault <= 1'b0;
      else        fault <= mode_fault || busy_fault;
   end

   assign ipi_dest      = req.dest;
   assign ipi_logical   = req.logical;
   assign ipi_delivery  = req.delivery;
   assign ipi_vector    = req.vector;
   assign ipi_level     = req.level;
   assign ipi_shorthand = req.shorthand;

   // R10: a fault only follows an access
   p_fault_after_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $past(acc_valid));

   // R3: a faulting access never starts a request
   p_fault_no_ipi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !$rose(ipi_valid));

   // R12: a refused write leaves a pending request in place
   p_busy_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ipi_valid && !ipi_ready && acc_valid) |=> ipi_valid);

endmodule

// File: tb/ic_regfront_test.sv
module ic_regfront_test;

   localparam logic [31:0] SID = 32'h0001_2345;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_mode = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_we = 1'b0;
   logic [11:0] acc_addr = '0;
   logic [3:0]  acc_size = 4'd4;
   logic [63:0] acc_wdata = '0;
   logic        ipi_ready = 1'b1;
   logic        rd_valid, fault, ipi_valid, ipi_logical, ipi_level;
   logic [63:0] rd_data;
   logic [31:0] ipi_dest;
   logic [2:0]  ipi_delivery;
   logic [7:0]  ipi_vector;
   logic [1:0]  ipi_shorthand;

   int compared = 0;
   int mismatched = 0;
   string tag = "R13";

   always #4 clk = ~clk;

   ic_regfront uut (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .strap_id(SID),
      .acc_valid(acc_valid), .acc_we(acc_we), .acc_addr(acc_addr),
      .acc_size(acc_size), .acc_wdata(acc_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .fault(fault),
      .ipi_valid(ipi_valid), .ipi_ready(ipi_ready), .ipi_dest(ipi_dest),
      .ipi_logical(ipi_logical), .ipi_delivery(ipi_delivery),
      .ipi_vector(ipi_vector), .ipi_level(ipi_level), .ipi_shorthand(ipi_shorthand)
   );

   // behavioural reference model
   logic        m_pv, m_dm, m_tr, m_fault, m_rv;
   logic [31:0] m_dest, m_lo, m_hi, m_err;
   logic [2:0]  m_dl;
   logic [7:0]  m_vec, m_id, m_lid;
   logic [1:0]  m_sh;
   logic [3:0]  m_fmt;
   logic [63:0] m_rd;

   always @(posedge clk) begin : model
      logic busy;
      logic nar;
      logic [7:0] ix;
      logic [15:0] onehot;
      if (!rst_n) begin
         m_pv = 0; m_dest = 0; m_dm = 0; m_dl = 0; m_vec = 0; m_tr = 0; m_sh = 0;
         m_fault = 0; m_rv = 0; m_rd = 0;
         m_id = SID[7:0]; m_lid = 0; m_fmt = 4'hF; m_lo = 0; m_hi = 0; m_err = 0;
      end else begin
         busy = m_pv && !ipi_ready;
         if (m_pv && ipi_ready) m_pv = 0;
         m_fault = 0; m_rv = 0; m_rd = 0;
         if (acc_valid) begin
            ix  = acc_addr[11:4];
            nar = !ext_mode && (acc_size < 4'd4);
            if (!acc_we) begin
               m_rv = 1;
               onehot = 16'd1 << SID[3:0];
               if (nar) m_rd = 0;
               else if (ext_mode && ix == 8'h0E) m_fault = 1;
               else case (ix)
                  8'h02: m_rd = ext_mode ? {32'b0, SID} : {32'b0, m_id, 24'b0};
                  8'h0D: m_rd = ext_mode ? {32'b0, SID[19:4], onehot} : {32'b0, m_lid, 24'b0};
                  8'h0E: m_rd = {32'b0, m_fmt, 28'hFFF_FFFF};
                  8'h28: m_rd = {32'b0, m_err};
                  8'h30: m_rd = ext_mode ? {m_hi, m_lo} : {32'b0, m_lo};
                  8'h31: m_rd = {32'b0, m_hi};
                  default: m_rd = 0;
               endcase
            end else if (!nar) begin
               if (ext_mode && (ix == 8'h02 || ix == 8'h0D || ix == 8'h0E || ix == 8'h31))
                  m_fault = 1;
               else if ((ix == 8'h30 || ix == 8'h3F) && busy)
                  m_fault = 1;
               else case (ix)
                  8'h02: m_id  = acc_wdata[31:24];
                  8'h0D: m_lid = acc_wdata[31:24];
                  8'h0E: m_fmt = acc_wdata[31:28];
                  8'h28: ;
                  8'h31: m_hi  = acc_wdata[31:0];
                  8'h30: begin
                     m_dest = ext_mode ? acc_wdata[63:32] : {24'b0, m_hi[31:24]};
                     m_lo = acc_wdata[31:0];
                     if (ext_mode) m_hi = acc_wdata[63:32];
                     m_vec = acc_wdata[7:0]; m_dl = acc_wdata[10:8]; m_dm = acc_wdata[11];
                     m_tr = acc_wdata[15]; m_sh = acc_wdata[19:18]; m_pv = 1;
                  end
                  8'h3F: begin
                     m_dest = 0; m_vec = acc_wdata[7:0]; m_dl = 0; m_dm = 0;
                     m_tr = 0; m_sh = 2'd1; m_pv = 1;
                  end
                  default: m_err[7] = 1'b1;
               endcase
            end
         end
      end
   end

   task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         check(fault === m_fault, "fault", 64'(fault), 64'(m_fault));
         check(rd_valid === m_rv, "rd_valid", 64'(rd_valid), 64'(m_rv));
         if (m_rv) check(rd_data === m_rd, "rd_data", rd_data, m_rd);
         check(ipi_valid === m_pv, "ipi_valid", 64'(ipi_valid), 64'(m_pv));
         if (m_pv)
            check({ipi_dest, ipi_logical, ipi_delivery, ipi_vector, ipi_level, ipi_shorthand} ===
                  {m_dest, m_dm, m_dl, m_vec, m_tr, m_sh}, "request",
                  64'({ipi_dest, ipi_logical, ipi_delivery, ipi_vector, ipi_level, ipi_shorthand}),
                  64'({m_dest, m_dm, m_dl, m_vec, m_tr, m_sh}));
      end
   end

   task automatic access(input bit we, input logic [7:0] ix, input logic [3:0] sz, input logic [63:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_we = we; acc_addr = {ix, 4'h0}; acc_size = sz; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_we = 1'b0;
   endtask

   // directed read with a constant expectation, sampled in the cycle after the access
   task automatic read_expect(input logic [7:0] ix, input logic [3:0] sz, input logic [63:0] exp);
      @(negedge clk);
      acc_valid = 1'b1; acc_we = 1'b0; acc_addr = {ix, 4'h0}; acc_size = sz;
      @(posedge clk); #2;
      check(rd_valid === 1'b1 && rd_data === exp, "directed read", rd_data, exp);
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #2;
      tag = "R13";
      check(!ipi_valid && !fault && !rd_valid, "reset outputs", 64'({ipi_valid, fault, rd_valid}), 64'd0);
      read_expect(8'h28, 4'd4, 64'd0);
      tag = "R6";  read_expect(8'h0E, 4'd4, 64'h0000_0000_FFFF_FFFF);
      access(1, 8'h0E, 4'd4, 64'h0000_0000_0000_0000);
      read_expect(8'h0E, 4'd4, 64'h0000_0000_0FFF_FFFF);
      tag = "R4";  read_expect(8'h02, 4'd4, 64'h0000_0000_4500_0000);
      access(1, 8'h02, 4'd4, 64'h0000_0000_AB00_0000);
      read_expect(8'h02, 4'd4, 64'h0000_0000_AB00_0000);
      tag = "R5";  access(1, 8'h0D, 4'd4, 64'h0000_0000_C300_0000);
      read_expect(8'h0D, 4'd4, 64'h0000_0000_C300_0000);
      tag = "R9";  access(1, 8'h02, 4'd2, 64'h0000_0000_1100_0000);
      read_expect(8'h02, 4'd1, 64'd0);
      read_expect(8'h02, 4'd4, 64'h0000_0000_AB00_0000);
      access(1, 8'h30, 4'd1, 64'h0000_0000_0000_0077);
      tag = "R1";  access(1, 8'h31, 4'd4, 64'h0000_0000_5A00_0000);
      ipi_ready = 1'b0;
      access(1, 8'h30, 4'd4, 64'h0000_0000_000C_8A31);
      tag = "R11"; repeat (4) @(negedge clk);
      @(posedge clk); #2;
      check(ipi_valid && ipi_dest == 32'h5A && ipi_vector == 8'h31 && ipi_delivery == 3'd2 &&
            ipi_logical && ipi_level && ipi_shorthand == 2'd3, "held legacy request",
            64'({ipi_dest, ipi_vector}), 64'({32'h5A, 8'h31}));
      tag = "R12"; access(1, 8'h30, 4'd4, 64'h0000_0000_0000_0042);
      @(negedge clk);
      acc_valid = 1'b1; acc_we = 1'b1; acc_addr = {8'h30, 4'h0}; acc_size = 4'd4;
      acc_wdata = 64'h0000_0000_0000_0555; ipi_ready = 1'b1;
      @(negedge clk);
      acc_valid = 1'b0; acc_we = 1'b0;
      repeat (2) @(negedge clk);
      tag = "R7";  access(1, 8'h3F, 4'd4, 64'h0000_0000_FFFF_8FE7);
      tag = "R8";  access(1, 8'h50, 4'd4, 64'd1);
      read_expect(8'h28, 4'd4, 64'h0000_0000_0000_0080);
      access(1, 8'h29, 4'd4, 64'd1);
      read_expect(8'h28, 4'd4, 64'h0000_0000_0000_0080);
      tag = "R2";  ext_mode = 1'b1;
      access(1, 8'h30, 4'd8, 64'hDEAD_BEEF_0000_40F1);
      read_expect(8'h31, 4'd8, 64'h0000_0000_DEAD_BEEF);
      read_expect(8'h30, 4'd8, 64'hDEAD_BEEF_0000_40F1);
      tag = "R5";  read_expect(8'h0D, 4'd8, 64'h0000_0000_1234_0020);
      tag = "R4";  read_expect(8'h02, 4'd8, 64'h0000_0000_0001_2345);
      tag = "R3";  access(1, 8'h02, 4'd8, 64'h0000_0000_1100_0000);
      access(1, 8'h0D, 4'd8, 64'h0000_0000_2200_0000);
      access(1, 8'h0E, 4'd8, 64'h0000_0000_F000_0000);
      access(1, 8'h31, 4'd8, 64'h0000_0000_1234_5678);
      read_expect(8'h0E, 4'd8, 64'd0);
      read_expect(8'h31, 4'd8, 64'h0000_0000_DEAD_BEEF);
      tag = "R7";  access(1, 8'h3F, 4'd8, 64'h0000_0000_0000_0099);
      tag = "R9";  access(1, 8'h3F, 4'd1, 64'h0000_0000_0000_0066);
      tag = "R3";  ext_mode = 1'b0;
      read_expect(8'h02, 4'd4, 64'h0000_0000_AB00_0000);
      read_expect(8'h0D, 4'd4, 64'h0000_0000_C300_0000);
      read_expect(8'h0E, 4'd4, 64'h0000_0000_0FFF_FFFF);
      tag = "R10"; access(1, 8'h30, 4'd4, 64'h0000_0000_0000_0011);
      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule